// File: doc/BRIEF.md
# Accumulator Readout and Saturation Unit

This block turns a 72-bit two's-complement accumulator into a register-sized result. A small opcode picks one of five operations. Three are raw slice reads: the low word, the middle word, or the 8-bit guard byte at the top. The other two narrow the whole accumulator to a signed 32-bit or a signed 64-bit integer. If the accumulator does not fit the target width, they clamp it to the nearest limit.

A caller presents the accumulator, the opcode and a one-cycle valid strobe. One clock later the block shows the result, a result-valid pulse, and a flag that reports whether a narrowing operation had to clamp. All 32-bit results are zero-extended onto the 64-bit result port. The block does not decode instructions, hold register files or perform multiply-accumulate.

Top module: `acc_readout`

## Requirements
- R1: While `rst_n` is low at a rising edge, `valid_o` and `sat_o` become 0 and `result_o` becomes zero.
- R2: `valid_o` is high in exactly the cycle after a rising edge that sampled `valid_i` high. It is low after any edge that sampled `valid_i` low.
- R3: Opcode 0 (low word) returns accumulator bits [31:0] in `result_o[31:0]`, with `result_o[63:32]` zero.
- R4: Opcode 1 (middle word) returns accumulator bits [63:32] in `result_o[31:0]`, with `result_o[63:32]` zero.
- R5: Opcode 2 (guard byte) returns accumulator bits [71:64] in `result_o[7:0]`, with `result_o[63:8]` zero.
- R6: Opcode 3 (narrow to 32) returns the accumulator clamped to [-2^31, 2^31-1] in `result_o[31:0]`, with `result_o[63:32]` zero. A value inside the range, including both limits, passes unchanged.
- R7: Opcode 4 (narrow to 64) returns the accumulator clamped to [-2^63, 2^63-1] in `result_o`. A value inside the range, including both limits, passes unchanged.
- R8: `sat_o` is high together with `valid_o` exactly when opcode 3 or 4 clamped the value. It is low for opcodes 0, 1, 2 and for undefined opcodes.
- R9: Opcodes 5, 6 and 7 are undefined. They still produce a `valid_o` pulse, with `result_o` zero.
- R10: When `valid_i` was low, `result_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_i | input | 72 | Signed accumulator value |
| op_i | input | 3 | Operation select (0..4 defined) |
| valid_i | input | 1 | Request strobe, one cycle per operation |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| sat_o | output | 1 | Narrowing operation clamped the value |

## Verification
The result and the clamp flag share one output cycle. Back-to-back strobes can therefore load a clamped narrowing result directly after a raw read, or the reverse, and the flag must rise and fall with the operation that owns the cycle. The bench issues such strobes with no gap, using accumulators placed exactly at, one past and one short of both narrowing limits. Random accumulators are biased toward those boundaries. Each output cycle is judged against reference functions that compute the slice or the clamped value and the expected flag from the requirement text.

// File: rtl/acc_readout_pkg.sv
// Shared widths and opcode encoding for the accumulator readout unit.
// Assumes a 72-bit two's-complement accumulator and a 64-bit result port.
package acc_readout_pkg;
    localparam int ACC_W = 72;
    localparam int RES_W = 64;
    localparam int WORD_W = 32;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOW   = 3'd0,
        OP_MID   = 3'd1,
        OP_GUARD = 3'd2,
        OP_NAR32 = 3'd3,
        OP_NAR64 = 3'd4
    } acc_op_e;
endpackage

// File: rtl/acc_slice_sel.sv
// Raw slice reads of the accumulator: low word, middle word, guard byte.
// Each slice is zero-extended to RES_W. Purely combinational.
// Assumes ACC_W = 2*WORD_W + guard width and RES_W >= WORD_W.
module acc_slice_sel #(
    parameter int ACC_W  = 72,
    parameter int WORD_W = 32,
    parameter int RES_W  = 64
) (
    input  logic [ACC_W-1:0] acc,
    output logic [RES_W-1:0] low_word,
    output logic [RES_W-1:0] mid_word,
    output logic [RES_W-1:0] guard_byte
);
    localparam int GUARD_W = ACC_W - 2*WORD_W;

    // Zero-extend each slice onto the result width.
    always_comb begin
        low_word   = '0;
        mid_word   = '0;
        guard_byte = '0;
        low_word[WORD_W-1:0]   = acc[WORD_W-1:0];
        mid_word[WORD_W-1:0]   = acc[2*WORD_W-1:WORD_W];
        guard_byte[GUARD_W-1:0] = acc[ACC_W-1:2*WORD_W];
    end
endmodule

// File: rtl/acc_clamp.sv
// Signed narrowing of the accumulator to OUT_W bits. Out-of-range values
// clamp to the largest positive or smallest negative OUT_W-bit value.
// Assumes OUT_W < ACC_W and OUT_W <= RES_W. Result is zero-extended.
module acc_clamp #(
    parameter int ACC_W = 72,
    parameter int OUT_W = 32,
    parameter int RES_W = 64
) (
    input  logic [ACC_W-1:0] acc,
    output logic [RES_W-1:0] value,
    output logic             clamped
);
    localparam int TOP_W = ACC_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             fits;
    logic [OUT_W-1:0] narrow;

    // In range when all bits from the target sign bit upward agree.
    always_comb begin
        top_bits = acc[ACC_W-1:OUT_W-1];
        fits     = (top_bits == '0) || (top_bits == '1);
    end

    // Pick the passed-through value or the limit matching the sign.
    always_comb begin
        if (fits) begin
            narrow = acc[OUT_W-1:0];
        end else begin
            narrow            = {OUT_W{~acc[ACC_W-1]}};
            narrow[OUT_W-1]   = acc[ACC_W-1];
        end
        value          = '0;
        value[OUT_W-1:0] = narrow;
        clamped        = ~fits;
    end
endmodule

// File: rtl/acc_readout.sv
// Top of the accumulator readout unit. Selects a slice read or a signed
// narrowing by opcode and registers result, valid and clamp flag with one
// cycle latency. Synchronous active-low reset. Assumes valid_i is low
// during reset.
module acc_readout
    import acc_readout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [71:0]      acc_i,
    input  logic [2:0]       op_i,
    input  logic             valid_i,
    output logic [63:0]      result_o,
    output logic             valid_o,
    output logic             sat_o
);
    localparam int N_NAR = RES_W / WORD_W;

    logic [RES_W-1:0] low_w, mid_w, guard_w;
    logic [RES_W-1:0] nar_val [N_NAR];
    logic [N_NAR-1:0] nar_clp;
    logic [RES_W-1:0] next_res;
    logic             next_sat;

    acc_slice_sel #(.ACC_W(ACC_W), .WORD_W(WORD_W), .RES_W(RES_W)) u_slice (
        .acc        (acc_i),
        .low_word   (low_w),
        .mid_word   (mid_w),
        .guard_byte (guard_w)
    );

    // One narrowing unit per multiple of the word width.
    for (genvar g = 0; g < N_NAR; g++) begin : g_nar
        acc_clamp #(.ACC_W(ACC_W), .OUT_W(WORD_W*(g+1)), .RES_W(RES_W)) u_clamp (
            .acc     (acc_i),
            .value   (nar_val[g]),
            .clamped (nar_clp[g])
        );
    end

    // Opcode select of result and clamp flag.
    always_comb begin
        next_res = '0;
        next_sat = 1'b0;
        case (op_i)
            OP_LOW:   next_res = low_w;
            OP_MID:   next_res = mid_w;
            OP_GUARD: next_res = guard_w;
            OP_NAR32: begin next_res = nar_val[0]; next_sat = nar_clp[0]; end
            OP_NAR64: begin next_res = nar_val[1]; next_sat = nar_clp[1]; end
            default:  next_res = '0;
        endcase
    end

    // Output register: result loads on a strobe, flags follow every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            valid_o  <= 1'b0;
            sat_o    <= 1'b0;
        end else begin
            valid_o <= valid_i;
            sat_o   <= valid_i & next_sat;
            if (valid_i) result_o <= next_res;
        end
    end

    // Assertion support: one cycle of history since reset release.
    logic hist_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (valid_o == $past(valid_i))); // R2
    AST_SAT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> valid_o); // R8
    AST_SAT_ONLY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && sat_o) |-> ($past(op_i) == OP_NAR32 || $past(op_i) == OP_NAR64)); // R8
    AST_GUARD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && valid_o && $past(op_i) == OP_GUARD) |-> (result_o[63:8] == '0)); // R5
    AST_NAR32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && valid_o && $past(op_i) == OP_NAR32) |-> (result_o[63:32] == '0)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !$past(valid_i)) |-> $stable(result_o)); // R10
endmodule

// File: tb/test_acc_readout.sv
module test_acc_readout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] acc_i = '0;
    logic [2:0]  op_i = '0;
    logic        valid_i = 1'b0;
    logic [63:0] result_o;
    logic        valid_o;
    logic        sat_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [63:0] last_res = '0;

    always #10 clk = ~clk;

    acc_readout i_acc_readout (.*);

    localparam logic signed [71:0] MAX32 = 72'sh7FFFFFFF;
    localparam logic signed [71:0] MIN32 = ~MAX32;
    localparam logic signed [71:0] MAX64 = 72'sh7FFFFFFFFFFFFFFF;
    localparam logic signed [71:0] MIN64 = ~MAX64;

    function automatic logic [63:0] exp_res(logic [71:0] a, logic [2:0] op);
        logic signed [71:0] s;
        s = a;
        case (op)
            3'd0: return {32'd0, a[31:0]};
            3'd1: return {32'd0, a[63:32]};
            3'd2: return {56'd0, a[71:64]};
            3'd3: begin
                if (s > MAX32) return 64'h7FFFFFFF;
                if (s < MIN32) return 64'h80000000;
                return {32'd0, a[31:0]};
            end
            3'd4: begin
                if (s > MAX64) return 64'h7FFFFFFFFFFFFFFF;
                if (s < MIN64) return 64'h8000000000000000;
                return a[63:0];
            end
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic exp_sat(logic [71:0] a, logic [2:0] op);
        logic signed [71:0] s;
        s = a;
        if (op == 3'd3) return (s > MAX32) || (s < MIN32);
        if (op == 3'd4) return (s > MAX64) || (s < MIN64);
        return 1'b0;
    endfunction

    function automatic string rtag(logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one strobe, check the registered outputs one clock later.
    task automatic run_op(logic [71:0] a, logic [2:0] op);
        @(negedge clk);
        acc_i = a; op_i = op; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check(rtag(op), result_o, exp_res(a, op));
        check("R8", {63'd0, sat_o}, {63'd0, exp_sat(a, op)});
        check("R2", {63'd0, valid_o}, 64'd1);
        last_res = exp_res(a, op);
    endtask

    // Back-to-back strobes with no idle cycle between them.
    task automatic run_pair(logic [71:0] a0, logic [2:0] o0, logic [71:0] a1, logic [2:0] o1);
        @(negedge clk);
        acc_i = a0; op_i = o0; valid_i = 1'b1;
        @(negedge clk);
        check(rtag(o0), result_o, exp_res(a0, o0));
        check("R8", {63'd0, sat_o}, {63'd0, exp_sat(a0, o0)});
        acc_i = a1; op_i = o1;
        @(negedge clk);
        valid_i = 1'b0;
        check(rtag(o1), result_o, exp_res(a1, o1));
        check("R8", {63'd0, sat_o}, {63'd0, exp_sat(a1, o1)});
        check("R2", {63'd0, valid_o}, 64'd1);
        last_res = exp_res(a1, o1);
    endtask

    function automatic logic [71:0] rnd_acc();
        logic [71:0] a;
        logic [71:0] sx;
        int m;
        a = {$urandom(), $urandom(), $urandom()};
        m = $urandom_range(0, 3);
        if (m == 1) begin
            sx = {72{a[31]}};
            a = {sx[71:32], a[31:0]};
            if ($urandom_range(0, 1) == 1) a[32] = ~a[32];
        end else if (m == 2) begin
            sx = {72{a[63]}};
            a = {sx[71:64], a[63:0]};
            if ($urandom_range(0, 1) == 1) a[64] = ~a[64];
        end
        return a;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", result_o, 64'd0);
        check("R1", {62'd0, valid_o, sat_o}, 64'd0);
        rst_n = 1'b1;

        // Directed slices
        run_op(72'hA5_0123456789ABCDEF, 3'd0);
        run_op(72'hA5_0123456789ABCDEF, 3'd1);
        run_op(72'hA5_0123456789ABCDEF, 3'd2);
        // Narrow-32 limits
        run_op(MAX32, 3'd3);
        run_op(MAX32 + 1, 3'd3);
        run_op(MIN32, 3'd3);
        run_op(MIN32 - 1, 3'd3);
        // Narrow-64 limits
        run_op(MAX64, 3'd4);
        run_op(MAX64 + 1, 3'd4);
        run_op(MIN64, 3'd4);
        run_op(MIN64 - 1, 3'd4);
        run_op({1'b0, {71{1'b1}}}, 3'd4);
        run_op({1'b1, 71'd0}, 3'd3);
        // Undefined opcodes
        run_op(72'hFF_FFFFFFFFFFFFFFFF, 3'd5);
        run_op(72'h12_3456789ABCDEF012, 3'd7);

        // Idle cycle: valid drops, result holds (R10)
        run_op(MAX64 + 5, 3'd4);
        @(negedge clk);
        acc_i = 72'h55_5555555555555555; op_i = 3'd0;
        @(negedge clk);
        check("R2", {63'd0, valid_o}, 64'd0);
        check("R10", result_o, last_res);
        check("R8", {63'd0, sat_o}, 64'd0);

        // Same-cycle interplay: clamp after raw read and the reverse
        run_pair(72'hFF_00000000FFFFFFFF, 3'd2, MAX32 + 1, 3'd3);
        run_pair(MIN64 - 1, 3'd4, MIN64 - 1, 3'd0);
        run_pair(MIN32 - 1, 3'd3, MAX64 + 1, 3'd4);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [71:0] a;
            logic [2:0] o;
            a = rnd_acc();
            o = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) != 0 && o > 3'd4) o = 3'($urandom_range(3, 4));
            run_op(a, o);
        end

        // Reset mid-run clears outputs (R1)
        @(negedge clk);
        acc_i = MAX64 + 1; op_i = 3'd4; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1", result_o, 64'd0);
        check("R1", {62'd0, valid_o, sat_o}, 64'd0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule